// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block looks for the integer divider settings of a frequency synthesiser that come closest to a requested output frequency. The synthesiser divides a reference clock by an input divider M, multiplies it by a feedback factor N to form the oscillator (VCO) frequency, and then divides that by a post-divide ratio picked by a small index. A caller supplies the reference frequency and the requested frequency, both in kHz, pulses `start`, and some time later receives M, N, the post-divide index, the frequency that those settings produce, and a one-cycle completion pulse.

The walk is sequential and visits one candidate at a time. Every quotient comes from a single shared restoring divider that produces one quotient bit per cycle. All limits are elaboration parameters: the oscillator range, the range of the comparison frequency (reference divided by M), the M, N and post-divide bounds, and the range that requests are clamped to. Two modes are offered. Exact mode keeps searching until the error is zero or the space is exhausted. Relaxed mode also stops at the first improving candidate whose error is below roughly 0.45 % of its oscillator frequency.

Top module: `pll_coeff_search`

## Requirements
- R1: `start` sampled while `busy_o` is low captures `ref_khz_i`, `req_khz_i` and `exact_i`. `busy_o` is high from the next cycle until the result cycle. In the result cycle `done_o` is high for exactly one cycle and `busy_o` is already low.
- R2: The request is clamped to [MIN_REQ, MAX_REQ] (144000..2064000 kHz by default) before the search begins.
- R3: The post-divide index selects the ratio 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32 for indices 0..14. Only indices lo..hi are searched. Let T = req + req/50 and Vmax = max(MAX_VCO, T). The upper bound is ceil(Vmax/T) and the lower bound is floor(MIN_VCO/T), each clamped to [MIN_PL, MAX_PL]. lo and hi are the lowest indices in 0..13 whose ratio is at least the respective bound (13 if none qualifies).
- R4: For each index, M runs upward from MIN_M to MAX_M. If ref/M is below MIN_U, that index is finished. If ref/M is above MAX_U, that M is skipped.
- R5: For each M, N takes the values from floor(req·ratio·M/ref) to the ceiling of the same quotient. If the floor exceeds MAX_N, that index is finished. Values below MIN_N are skipped, and a value above MAX_N ends that M.
- R6: A candidate qualifies only if VCO = floor(ref·N/M) lies in [MIN_VCO, Vmax]. Its output is floor((VCO + ratio/2)/ratio), and its error is the absolute difference from the request. It becomes the best only if its error is strictly smaller than the current best, so among equal errors the first one found is kept.
- R7: The search stops immediately when a new best has zero error. When `exact_i` was low, it also stops when the new best satisfies floor(VCO/error) > 218.
- R8: `freq_khz_o` = floor(ref·N/(M·ratio)) for the reported M, N and index.
- R9: If no candidate qualifies, `err_o` is high and the result is M = MAX_M, N = MIN_N, index 0, with `freq_khz_o` computed from those values. Otherwise `err_o` is low.
- R10: `start` while `busy_o` is high is ignored: the running search and its result are unaffected.
- R11: After reset all outputs are zero. The result outputs hold their values from the result cycle until the next result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| exact_i | input | 1 | 1: stop only on zero error; 0: allow early stop |
| ref_khz_i | input | FW | Reference frequency in kHz |
| req_khz_i | input | FW | Requested output frequency in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | No candidate qualified |
| m_o | output | MW | Chosen input divider |
| n_o | output | NW | Chosen feedback multiplier |
| pl_o | output | 4 | Chosen post-divide index |
| freq_khz_o | output | FW | Frequency produced by the chosen settings |

## Verification
A `start` can arrive in the very cycle that a search finishes or in any cycle while a search is running, and the result must still belong to the search that was accepted. The bench issues a second `start` with different operands part-way through a search and compares the final result with the reference model's answer for the first operands. It also checks on every clock that the held outputs did not move. In the comparison stage, an early-stop decision and a best-so-far update fall on the same candidate. Relaxed-mode and zero-error runs show whether the stop took the just-updated best and not the previous one.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int PL_SEARCH_LAST = 13;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HI, ST_LO, ST_PLSET, ST_MSET, ST_U, ST_N,
    ST_NCHK, ST_V, ST_L, ST_CMP, ST_FIN, ST_F
  } srch_st_e;

  typedef enum logic [2:0] {
    ADV_NONE, ADV_N, ADV_M, ADV_PL, ADV_STOP
  } srch_adv_e;

  // post-divide ratio for an index; ordering is behaviour
  function automatic logic [5:0] pl_ratio(input logic [3:0] idx);
    case (idx)
      4'd0: pl_ratio = 6'd1;   4'd1: pl_ratio = 6'd2;
      4'd2: pl_ratio = 6'd3;   4'd3: pl_ratio = 6'd4;
      4'd4: pl_ratio = 6'd5;   4'd5: pl_ratio = 6'd6;
      4'd6: pl_ratio = 6'd8;   4'd7: pl_ratio = 6'd10;
      4'd8: pl_ratio = 6'd12;  4'd9: pl_ratio = 6'd16;
      4'd10: pl_ratio = 6'd12; 4'd11: pl_ratio = 6'd16;
      4'd12: pl_ratio = 6'd20; 4'd13: pl_ratio = 6'd24;
      default: pl_ratio = 6'd32;
    endcase
  endfunction

  // lowest searched index whose ratio reaches the bound
  function automatic logic [3:0] first_pl_at_least(input logic [5:0] bound);
    logic [3:0] pick;
    pick = 4'(PL_SEARCH_LAST);
    for (int i = PL_SEARCH_LAST; i >= 0; i--)
      if (pl_ratio(4'(i)) >= bound) pick = 4'(i);
    return pick;
  endfunction

endpackage

// File: rtl/pll_div_restoring.sv
module pll_div_restoring #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, r_r, d_r, n_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    r_sh, r_sub;
  logic          ge;

  always_comb begin
    r_sh  = {r_r, q_r[W-1]};
    ge    = (r_sh >= {1'b0, d_r});
    r_sub = r_sh - {1'b0, d_r};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r <= '0; r_r <= '0; d_r <= '0; n_r <= '0;
      cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        q_r <= num; r_r <= '0; d_r <= den; n_r <= num;
        cnt <= CW'(W); run <= 1'b1;
      end else if (run) begin
        r_r <= ge ? r_sub[W-1:0] : r_sh[W-1:0];
        q_r <= {q_r[W-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = q_r;
  assign rem = r_r;

  AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    done && (d_r != '0) |->
      ((2*W)'(quo) * (2*W)'(d_r) + (2*W)'(rem) == (2*W)'(n_r)) && (rem < d_r)); // R8

endmodule

// File: rtl/pll_pl_index.sv
module pll_pl_index (
  input  logic [5:0] bound,
  output logic [3:0] idx
);
  import pll_search_pkg::*;
  assign idx = first_pl_at_least(bound);
endmodule

// File: rtl/pll_coeff_search.sv
module pll_coeff_search #(
  parameter int FW      = 24,
  parameter int MW      = 8,
  parameter int NW      = 8,
  parameter int DW      = 40,
  parameter int MIN_VCO = 1000000,
  parameter int MAX_VCO = 2064000,
  parameter int MIN_U   = 12000,
  parameter int MAX_U   = 38000,
  parameter int MIN_M   = 1,
  parameter int MAX_M   = 255,
  parameter int MIN_N   = 8,
  parameter int MAX_N   = 255,
  parameter int MIN_PL  = 1,
  parameter int MAX_PL  = 32,
  parameter int MIN_REQ = 144000,
  parameter int MAX_REQ = 2064000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          exact_i,
  input  logic [FW-1:0] ref_khz_i,
  input  logic [FW-1:0] req_khz_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [MW-1:0] m_o,
  output logic [NW-1:0] n_o,
  output logic [3:0]    pl_o,
  output logic [FW-1:0] freq_khz_o
);
  import pll_search_pkg::*;

  localparam int XW = DW + 8;
  localparam logic [DW-1:0] K_MIN_VCO = DW'(MIN_VCO);
  localparam logic [DW-1:0] K_MAX_VCO = DW'(MAX_VCO);
  localparam logic [DW-1:0] K_MIN_U   = DW'(MIN_U);
  localparam logic [DW-1:0] K_MAX_U   = DW'(MAX_U);
  localparam logic [DW-1:0] K_MIN_N   = DW'(MIN_N);
  localparam logic [DW-1:0] K_MAX_N   = DW'(MAX_N);
  localparam logic [FW-1:0] K_MIN_REQ = FW'(MIN_REQ);
  localparam logic [FW-1:0] K_MAX_REQ = FW'(MAX_REQ);

  srch_st_e  st;
  srch_adv_e adv;
  logic          pend;
  logic [FW-1:0] ref_r, req_r;
  logic          exact_r;
  logic [DW-1:0] tvco, vmax, tv, n, n2, vco, lwv, best_delta, delta;
  logic [5:0]    bnd [2];
  logic [3:0]    bidx [2];
  logic [3:0]    pl, best_pl;
  logic [MW-1:0] m, best_m;
  logic [NW-1:0] best_n;

  // named internal events for the assertions
  logic cand_ok, best_upd, stop_hit, fin, m_last, pl_last;

  // arithmetic helpers
  function automatic logic [FW-1:0] clamp_req(input logic [FW-1:0] r);
    if (r < K_MIN_REQ) return K_MIN_REQ;
    if (r > K_MAX_REQ) return K_MAX_REQ;
    return r;
  endfunction

  function automatic logic [5:0] clamp_bound(input logic [DW-1:0] q);
    if (q < DW'(MIN_PL)) return 6'(MIN_PL);
    if (q > DW'(MAX_PL)) return 6'(MAX_PL);
    return q[5:0];
  endfunction

  function automatic logic [DW-1:0] abs_diff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a >= b) ? a - b : b - a;
  endfunction

  // clamped request and working VCO target for the start cycle
  logic [FW-1:0] req_c;
  logic [DW-1:0] tvco_c;
  always_comb begin
    req_c  = clamp_req(req_khz_i);
    tvco_c = DW'(req_c) + DW'(req_c) / DW'(50);
  end

  // PL window index mappers, one per bound
  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_plmap
      pll_pl_index u_map (.bound(bnd[gi]), .idx(bidx[gi]));
    end
  endgenerate

  // shared divider
  logic          div_go, div_done;
  logic [DW-1:0] div_num, div_den, div_q, div_r;
  logic          div_state;

  always_comb begin
    div_state = 1'b1;
    div_num   = '0;
    div_den   = DW'(1);
    case (st)
      ST_HI: begin div_num = vmax + tvco - DW'(1); div_den = tvco; end
      ST_LO: begin div_num = K_MIN_VCO;            div_den = tvco; end
      ST_U:  begin div_num = DW'(ref_r);           div_den = DW'(m); end
      ST_N:  begin div_num = tv * DW'(m);          div_den = DW'(ref_r); end
      ST_V:  begin div_num = DW'(ref_r) * n;       div_den = DW'(m); end
      ST_L:  begin
        div_num = vco + DW'(pl_ratio(pl) >> 1);
        div_den = DW'(pl_ratio(pl));
      end
      ST_F:  begin
        div_num = DW'(ref_r) * DW'(best_n);
        div_den = DW'(best_m) * DW'(pl_ratio(best_pl));
      end
      default: div_state = 1'b0;
    endcase
  end

  assign div_go = div_state && !pend;
  assign fin    = pend && div_done;

  pll_div_restoring #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_q), .rem(div_r)
  );

  // candidate evaluation and loop advance decisions
  always_comb begin
    adv      = ADV_NONE;
    cand_ok  = 1'b0;
    best_upd = 1'b0;
    stop_hit = 1'b0;
    delta    = abs_diff(lwv, DW'(req_r));
    m_last   = (m >= MW'(MAX_M));
    pl_last  = (pl >= bidx[1]);
    case (st)
      ST_U: if (fin) begin
        if (div_q < K_MIN_U)      adv = ADV_PL;
        else if (div_q > K_MAX_U) adv = ADV_M;
      end
      ST_N: if (fin && div_q > K_MAX_N) adv = ADV_PL;
      ST_NCHK: begin
        if (n > n2)            adv = ADV_M;
        else if (n < K_MIN_N)  adv = ADV_N;
        else if (n > K_MAX_N)  adv = ADV_M;
      end
      ST_V: if (fin && (div_q < K_MIN_VCO || div_q > vmax)) adv = ADV_N;
      ST_CMP: begin
        cand_ok  = 1'b1;
        best_upd = (delta < best_delta);
        stop_hit = best_upd && ((delta == '0) ||
                   (!exact_r && (XW'(vco) >= XW'(delta) * XW'(219))));
        adv = stop_hit ? ADV_STOP : ADV_N;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; pend <= 1'b0;
      ref_r <= '0; req_r <= '0; exact_r <= 1'b0;
      tvco <= DW'(1); vmax <= '0; tv <= '0;
      n <= '0; n2 <= '0; vco <= '0; lwv <= '0;
      bnd[0] <= 6'd1; bnd[1] <= 6'd1;
      pl <= '0; m <= '0;
      best_delta <= '1; best_m <= '0; best_n <= '0; best_pl <= '0;
      busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
      m_o <= '0; n_o <= '0; pl_o <= '0; freq_khz_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (div_go)    pend <= 1'b1;
      else if (fin)  pend <= 1'b0;

      if (best_upd) begin
        best_delta <= delta;
        best_m     <= m;
        best_n     <= NW'(n);
        best_pl    <= pl;
      end

      if (fin && st == ST_N) begin
        n  <= div_q;
        n2 <= div_q + ((div_r != '0) ? DW'(1) : DW'(0));
      end

      case (adv)
        ADV_N: begin n <= n + DW'(1); st <= ST_NCHK; end
        ADV_M: begin
          if (!m_last) begin m <= m + 1'b1; st <= ST_U; end
          else if (pl_last) st <= ST_FIN;
          else begin pl <= pl + 1'b1; st <= ST_MSET; end
        end
        ADV_PL: begin
          if (pl_last) st <= ST_FIN;
          else begin pl <= pl + 1'b1; st <= ST_MSET; end
        end
        ADV_STOP: st <= ST_FIN;
        default: begin
          case (st)
            ST_IDLE: if (start) begin
              ref_r <= ref_khz_i; req_r <= req_c; exact_r <= exact_i;
              tvco <= tvco_c;
              vmax <= (K_MAX_VCO < tvco_c) ? tvco_c : K_MAX_VCO;
              best_delta <= '1;
              best_m <= MW'(MAX_M); best_n <= NW'(MIN_N); best_pl <= '0;
              busy_o <= 1'b1;
              st <= ST_HI;
            end
            ST_HI: if (fin) begin bnd[1] <= clamp_bound(div_q); st <= ST_LO; end
            ST_LO: if (fin) begin bnd[0] <= clamp_bound(div_q); st <= ST_PLSET; end
            ST_PLSET: begin
              if (bidx[0] > bidx[1]) st <= ST_FIN;
              else begin pl <= bidx[0]; st <= ST_MSET; end
            end
            ST_MSET: begin
              tv <= DW'(req_r) * DW'(pl_ratio(pl));
              m  <= MW'(MIN_M);
              st <= ST_U;
            end
            ST_U:    if (fin) st <= ST_N;
            ST_N:    if (fin) st <= ST_NCHK;
            ST_NCHK: st <= ST_V;
            ST_V:    if (fin) begin vco <= div_q; st <= ST_L; end
            ST_L:    if (fin) begin lwv <= div_q; st <= ST_CMP; end
            ST_FIN:  st <= ST_F;
            ST_F: if (fin) begin
              freq_khz_o <= FW'(div_q);
              m_o    <= best_m;
              n_o    <= best_n;
              pl_o   <= best_pl;
              err_o  <= (best_delta == '1);
              done_o <= 1'b1;
              busy_o <= 1'b0;
              st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
          endcase
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R1
  AST_CAND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ok |-> (vco >= K_MIN_VCO) && (vco <= vmax)); // R6
  AST_BEST_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> best_delta <= $past(best_delta)); // R6
  AST_RESULT_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> (m_o >= MW'(MIN_M)) && (m_o <= MW'(MAX_M)) &&
      (n_o >= NW'(MIN_N)) && (n_o <= NW'(MAX_N)) && (pl_o <= 4'(PL_SEARCH_LAST))); // R5
  AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && err_o |-> (m_o == MW'(MAX_M)) && (n_o == NW'(MIN_N)) && (pl_o == 4'd0)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start |=> $stable(ref_r) && $stable(req_r)); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(m_o) || done_o); // R11

endmodule

// File: tb/tb_pll_coeff_search.sv
module tb_pll_coeff_search;
  localparam int FW = 24;
  localparam int RAT [15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic exact_i = 1'b0;
  logic [FW-1:0] ref_khz_i = '0, req_khz_i = '0;
  logic busy_o, done_o, err_o;
  logic [7:0] m_o, n_o;
  logic [3:0] pl_o;
  logic [FW-1:0] freq_khz_o;

  always #4 clk = ~clk;

  pll_coeff_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .exact_i(exact_i),
    .ref_khz_i(ref_khz_i), .req_khz_i(req_khz_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .m_o(m_o), .n_o(n_o), .pl_o(pl_o),
    .freq_khz_o(freq_khz_o)
  );

  int checks = 0;
  int fails = 0;
  bit hold_ok = 0;
  longint e_m, e_n, e_pl, e_f;
  bit e_err;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference of the search
  task automatic model(input longint rf, input longint rq_in, input bit ex,
                       output longint om, output longint on, output longint op,
                       output longint ofr, output bit oe);
    longint rq, tgt, vhi, hb, lb, lo, hi, bd, tv, u, nf, nc, v, lw, dl;
    bit stop;
    rq  = (rq_in < 144000) ? 144000 : (rq_in > 2064000 ? 2064000 : rq_in);
    tgt = rq + rq / 50;
    vhi = (tgt > 2064000) ? tgt : 2064000;
    hb  = (vhi + tgt - 1) / tgt;
    lb  = 1000000 / tgt;
    if (hb > 32) hb = 32; if (hb < 1) hb = 1;
    if (lb > 32) lb = 32; if (lb < 1) lb = 1;
    lo = 13; hi = 13;
    for (int i = 0; i <= 13; i++) if (RAT[i] >= lb) begin lo = i; break; end
    for (int i = 0; i <= 13; i++) if (RAT[i] >= hb) begin hi = i; break; end
    bd = 64'h7fff_ffff_ffff; om = 255; on = 8; op = 0; stop = 0;
    for (longint p = lo; p <= hi && !stop; p++) begin
      tv = rq * RAT[p];
      for (longint mm = 1; mm <= 255 && !stop; mm++) begin
        u = rf / mm;
        if (u < 12000) break;
        if (u > 38000) continue;
        nf = (tv * mm) / rf;
        nc = (tv * mm + rf - 1) / rf;
        if (nf > 255) break;
        for (longint nn = nf; nn <= nc && !stop; nn++) begin
          if (nn < 8) continue;
          if (nn > 255) break;
          v = rf * nn / mm;
          if (v >= 1000000 && v <= vhi) begin
            lw = (v + RAT[p] / 2) / RAT[p];
            dl = (lw > rq) ? lw - rq : rq - lw;
            if (dl < bd) begin
              bd = dl; om = mm; on = nn; op = p;
              if (dl == 0 || (!ex && v / dl > 218)) stop = 1;
            end
          end
        end
      end
    end
    oe  = (bd == 64'h7fff_ffff_ffff);
    ofr = rf * on / (om * RAT[op]);
  endtask

  // every clock: held result must not move (R11)
  always @(negedge clk) begin
    if (hold_ok && rst_n) begin
      chk("R11", "held m", m_o, e_m);
      chk("R11", "held freq", freq_khz_o, e_f);
    end
  end

  task automatic launch(input longint rf, input longint rq, input bit ex);
    @(negedge clk);
    hold_ok = 0;
    ref_khz_i = FW'(rf); req_khz_i = FW'(rq); exact_i = ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run(input string tag, input longint rf, input longint rq, input bit ex,
                            input int poke_at, input longint prf, input longint prq);
    int wd;
    bit busy_seen;
    model(rf, rq, ex, e_m, e_n, e_pl, e_f, e_err);
    wd = 0;
    busy_seen = 1;
    while (!done_o && wd < 40000) begin
      if (!busy_o) busy_seen = 0;
      if (wd == poke_at) begin
        ref_khz_i = FW'(prf); req_khz_i = FW'(prq); exact_i = !ex; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
      wd++;
    end
    if (!done_o) begin
      checks++; fails++;
      $display("FAIL %s watchdog: actual no done expected done", tag);
      return;
    end
    chk("R1", "busy held until done", busy_seen, 1);
    chk("R1", "busy low with done", busy_o, 0);
    chk(tag, "m (R4)", m_o, e_m);
    chk(tag, "n (R5)", n_o, e_n);
    chk(tag, "pl (R3)", pl_o, e_pl);
    chk(tag, "freq (R8)", freq_khz_o, e_f);
    chk(tag, "err (R9)", err_o, e_err);
    @(negedge clk);
    chk("R1", "done single cycle", done_o, 0);
    hold_ok = 1;
  endtask

  task automatic run(input string tag, input longint rf, input longint rq, input bit ex);
    launch(rf, rq, ex);
    finish_run(tag, rf, rq, ex, -1, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL global watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset busy", busy_o, 0);
    chk("R11", "reset done", done_o, 0);
    chk("R11", "reset err", err_o, 0);
    chk("R11", "reset freq", freq_khz_o, 0);

    run("R6", 12000, 1000000, 1'b1);
    chk("R6", "best is m1 n167 pl1", {m_o, n_o, pl_o}, {8'd1, 8'd167, 4'd1});
    run("R7", 12000, 600000, 1'b1);
    chk("R7", "zero error stop freq", freq_khz_o, 600000);
    run("R7", 38400, 852000, 1'b0);
    run("R7", 38400, 852000, 1'b1);
    run("R4", 38400, 1450000, 1'b1);
    run("R5", 19200, 333000, 1'b0);
    run("R3", 12000, 2000000, 1'b1);
    run("R2", 12000, 100000, 1'b1);
    chk("R2", "low clamp equals floor", freq_khz_o >= 140000, 1);
    run("R2", 13000, 3000000, 1'b1);
    run("R9", 5000, 800000, 1'b1);
    chk("R9", "fallback m", m_o, 255);

    // a second start mid-search must be ignored
    launch(26000, 700000, 1'b1);
    finish_run("R10", 26000, 700000, 1'b1, 20, 12000, 1500000);
    run("R8", 27000, 456789, 1'b0);

    hold_ok = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule